// File: doc/BRIEF.md
# Mode-Selectable Programmable Frequency Divider

This block divides its clock by a programmed number N and emits one output pulse every N clocks. The count is held in three cascaded sections. A fast first section has a modulus of 10, 8, 5, 4 or 2, chosen at run time by a three-bit mode code. A middle section is made of three cascaded decade stages. A slow top section uses the bits of the four-bit first-section register that the chosen modulus leaves free. A sixteen-bit jam word supplies the starting count. When the count runs out, the block reloads the jam word in the same clock in which the pulse appears.

One mode code parks the whole counter in a hold state that keeps loading the jam word. Counting begins one arming clock after the mode code leaves that state. A pulse that is one or two clocks away when the hold state starts is still delivered on time. A latch input can keep the output high after a pulse until it is released. The usual uses are channel-step frequency synthesis and fixed or programmable timeouts. The design uses one clock and a synchronous active-high reset.

Top module: `ndiv_counter`

## Requirements
- R1: The mode code is {mode_sel[2], mode_sel[1], mode_sel[0]}. 110 divides the first section by 10, 011 by 8, 101 and 001 by 5, 010 by 4, and 111 by 2. Codes 000 and 100 select the preset-hold state.
- R2: The decades take their presets from jam[7:4] (weight 1), jam[11:8] (weight 10) and jam[15:12] (weight 100), and each accepts any value from 0 to 15. The low `u` bits of jam[3:0] preset the first section, where u is 4, 3, 3, 2 or 1 for modulus 10, 8, 5, 4 or 2. The remaining upper bits of jam[3:0] preset the top section, which has weight 1000.
- R3: With F the first-section preset, M the modulus, D1..D3 the decade presets and L the top-section preset, the output period is N = M*(D1 + 10*D2 + 100*D3 + 1000*L) + F for any N of 3 or more. With latch_en low, each pulse is high for exactly one clock.
- R4: Outside the hold state, the jam word is reloaded in the clock in which the pulse appears, so consecutive pulses are exactly N clocks apart.
- R5: While the hold state lasts, the counter keeps loading the jam word. From the third consecutive hold clock onward, div_out stays low when latch_en is low.
- R6: The first clock edge that sees a divide mode after the hold state only arms the counter and leaves the count unchanged. The first pulse is therefore high after the (N+1)th such edge.
- R7: If the hold state is first seen at the edge at which the pulse was one or two edges away, the pulse still appears at its due time. If the pulse was three edges away, no pulse appears at that time.
- R8: With latch_en high, div_out stays high from a pulse onward. It falls at the first edge that sees latch_en low, unless a new pulse is due at that edge.
- R9: Reset clears div_out and the arming state and loads the jam word. After reset is released in a divide mode, the first pulse is high after the (N+1)th edge.
- R10: In divide-by-8 mode with jam = 16'hFFFF, the period is 21327 clocks: 8*(15 + 150 + 1500 + 1000) + 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 3 | Mode code: first-section modulus or preset hold |
| jam | input | 16 | Preset word for the first, decade and top sections |
| latch_en | input | 1 | Holds div_out high after a pulse while high |
| div_out | output | 1 | Divided pulse output |

## Verification
The bench runs every divide mode, including the alias code, against a set of jam words. The words are chosen so that the first-section bits spill into the top section differently in each mode and so that decades are loaded above nine. A design that split the low nibble at the wrong bit, or that wrapped a decade at nine before counting down, would give a period different from the arithmetic model. The bench also checks the arming clock after the hold state and after reset, where a design that started counting at once would pulse one clock early. Finally, it enters the hold state one, two and three edges before a pulse is due. A design without the pending-pulse memory would drop the on-time pulse, and one that ignored the hold state would emit a pulse that should not appear.

// File: rtl/ndiv_pkg.sv
package ndiv_pkg;

    // Width of the shared first/top-section register
    localparam int FL_W = 4;

    typedef enum logic [2:0] {
        MODE_HOLD,
        MODE_DIV10,
        MODE_DIV8,
        MODE_DIV5,
        MODE_DIV4,
        MODE_DIV2
    } ndiv_mode_e;

    typedef struct packed {
        logic            hold;     // preset-hold state
        logic [FL_W-1:0] modulus;  // first-section modulus
        logic [2:0]      used;     // bits of the shared register owned by the first section
    } ndiv_cfg_t;

    // sel = {a, b, c}
    function automatic ndiv_mode_e decode_mode(input logic [2:0] sel);
        ndiv_mode_e m;
        case (sel[1:0])
            2'b00:   m = MODE_HOLD;
            2'b01:   m = MODE_DIV5;
            2'b10:   m = sel[2] ? MODE_DIV10 : MODE_DIV4;
            default: m = sel[2] ? MODE_DIV2  : MODE_DIV8;
        endcase
        return m;
    endfunction

    function automatic ndiv_cfg_t mode_cfg(input ndiv_mode_e m);
        ndiv_cfg_t c;
        c.hold    = 1'b0;
        c.modulus = FL_W'(10);
        c.used    = 3'd4;
        case (m)
            MODE_DIV10: begin c.modulus = FL_W'(10); c.used = 3'd4; end
            MODE_DIV8:  begin c.modulus = FL_W'(8);  c.used = 3'd3; end
            MODE_DIV5:  begin c.modulus = FL_W'(5);  c.used = 3'd3; end
            MODE_DIV4:  begin c.modulus = FL_W'(4);  c.used = 3'd2; end
            MODE_DIV2:  begin c.modulus = FL_W'(2);  c.used = 3'd1; end
            default:    c.hold = 1'b1;
        endcase
        return c;
    endfunction

    function automatic logic [FL_W-1:0] low_mask(input logic [2:0] used);
        return FL_W'((32'd1 << used) - 32'd1);
    endfunction

endpackage

// File: rtl/ndiv_mode_dec.sv
module ndiv_mode_dec
    import ndiv_pkg::*;
(
    input  logic [2:0] mode_sel,
    output ndiv_cfg_t  cfg
);

    ndiv_mode_e mode;

    always_comb begin
        mode = decode_mode(mode_sel);
        cfg  = mode_cfg(mode);
    end

endmodule

// File: rtl/ndiv_first.sv
module ndiv_first
    import ndiv_pkg::*;
(
    input  logic [FL_W-1:0] fl_q,
    input  ndiv_cfg_t       cfg,
    input  logic            step,
    output logic [FL_W-1:0] first_val,
    output logic [FL_W-1:0] first_next,
    output logic            borrow
);

    always_comb begin
        first_val  = fl_q & low_mask(cfg.used);
        first_next = first_val;
        borrow     = 1'b0;
        if (step) begin
            if (first_val == '0) begin
                first_next = cfg.modulus - FL_W'(1);
                borrow     = 1'b1;
            end else begin
                first_next = first_val - FL_W'(1);
            end
        end
    end

endmodule

// File: rtl/ndiv_decade.sv
module ndiv_decade #(
    parameter int DIG_W   = 4,
    parameter int DIG_TOP = 9
) (
    input  logic [DIG_W-1:0] d_q,
    input  logic             borrow_in,
    output logic [DIG_W-1:0] d_next,
    output logic             borrow_out
);

    localparam logic [DIG_W-1:0] WRAP = DIG_W'(DIG_TOP);

    always_comb begin
        borrow_out = borrow_in && (d_q == '0);
        d_next     = d_q;
        if (borrow_in) begin
            d_next = (d_q == '0) ? WRAP : d_q - DIG_W'(1);
        end
    end

endmodule

// File: rtl/ndiv_last.sv
module ndiv_last
    import ndiv_pkg::*;
(
    input  logic [FL_W-1:0] fl_q,
    input  ndiv_cfg_t       cfg,
    input  logic            borrow_in,
    output logic [FL_W-1:0] last_val,
    output logic [FL_W-1:0] last_next,
    output logic [FL_W-1:0] last_placed
);

    always_comb begin
        last_val    = fl_q >> cfg.used;
        last_next   = borrow_in ? last_val - FL_W'(1) : last_val;
        last_placed = last_next << cfg.used;
    end

endmodule

// File: rtl/ndiv_counter.sv
module ndiv_counter
    import ndiv_pkg::*;
#(
    parameter  int DIGITS  = 3,
    parameter  int DIG_W   = 4,
    parameter  int DIG_TOP = 9,
    localparam int JAM_W   = FL_W + DIGITS * DIG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode_sel,
    input  logic [JAM_W-1:0] jam,
    input  logic             latch_en,
    output logic             div_out
);

    ndiv_cfg_t cfg;
    logic      hold_w;

    logic [FL_W-1:0] fl_q;
    logic [FL_W-1:0] first_val, first_next;
    logic [FL_W-1:0] last_val, last_next, last_placed;

    logic [DIGITS-1:0][DIG_W-1:0] dec_q, dec_next;
    logic [DIGITS:0]              chain;

    logic armed_q;   // set one edge after leaving the hold state
    logic owed_q;    // pulse still due after the hold state begins
    logic out_q;

    logic counting, at_one, next_one, reload, pulse;

    ndiv_mode_dec i_mode_dec (
        .mode_sel (mode_sel),
        .cfg      (cfg)
    );

    assign hold_w = cfg.hold;

    ndiv_first i_first (
        .fl_q       (fl_q),
        .cfg        (cfg),
        .step       (armed_q),
        .first_val  (first_val),
        .first_next (first_next),
        .borrow     (chain[0])
    );

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_dec
        ndiv_decade #(
            .DIG_W   (DIG_W),
            .DIG_TOP (DIG_TOP)
        ) i_dec (
            .d_q        (dec_q[gi]),
            .borrow_in  (chain[gi]),
            .d_next     (dec_next[gi]),
            .borrow_out (chain[gi+1])
        );
    end

    ndiv_last i_last (
        .fl_q        (fl_q),
        .cfg         (cfg),
        .borrow_in   (chain[DIGITS]),
        .last_val    (last_val),
        .last_next   (last_next),
        .last_placed (last_placed)
    );

    always_comb begin
        counting = armed_q && !cfg.hold;
        at_one   = (first_val == FL_W'(1)) && (last_val == '0) && (dec_q == '0);
        next_one = (first_next == FL_W'(1)) && (last_next == '0) && (dec_next == '0);
        reload   = cfg.hold || (counting && at_one);
        pulse    = (armed_q && at_one) || owed_q;
    end

    always_ff @(posedge clk) begin
        if (rst || reload) begin
            fl_q  <= jam[FL_W-1:0];
            dec_q <= jam[JAM_W-1:FL_W];
        end else if (counting) begin
            fl_q  <= first_next | last_placed;
            dec_q <= dec_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            owed_q  <= 1'b0;
            out_q   <= 1'b0;
        end else begin
            armed_q <= !cfg.hold;
            owed_q  <= armed_q && cfg.hold && next_one;
            out_q   <= pulse || (latch_en && out_q);
        end
    end

    assign div_out = out_q;

endmodule

// File: rtl/ndiv_counter_chk.sv
module ndiv_counter_chk
    import ndiv_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            latch_en,
    input logic            div_out,
    input logic            hold,
    input logic            armed,
    input logic [FL_W-1:0] fl_q
);

    a_r3_single_clock_pulse: assert property (@(posedge clk) disable iff (rst)
        (div_out && !latch_en) |=> !div_out);

    a_r5_hold_silent: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && $past(hold, 2) && !latch_en) |=> !div_out);

    a_r6_arming_edge_still: assert property (@(posedge clk) disable iff (rst)
        (!hold && !armed) |=> $stable(fl_q));

    a_r8_latch_keeps_high: assert property (@(posedge clk) disable iff (rst)
        (latch_en && div_out) |=> div_out);

endmodule

bind ndiv_counter ndiv_counter_chk i_ndiv_chk (
    .clk      (clk),
    .rst      (rst),
    .latch_en (latch_en),
    .div_out  (div_out),
    .hold     (hold_w),
    .armed    (armed_q),
    .fl_q     (fl_q)
);

// File: tb/test_ndiv_counter.sv
module test_ndiv_counter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_sel = 3'b110;
    logic [15:0] jam = 16'h0005;
    logic        latch_en = 1'b0;
    logic        div_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ndiv_counter i_ndiv_counter (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .jam      (jam),
        .latch_en (latch_en),
        .div_out  (div_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_n(input logic [2:0] sel, input logic [15:0] j);
        int m, u, f, l;
        case (sel)
            3'b110:         begin m = 10; u = 4; end
            3'b011:         begin m = 8;  u = 3; end
            3'b101, 3'b001: begin m = 5;  u = 3; end
            3'b010:         begin m = 4;  u = 2; end
            3'b111:         begin m = 2;  u = 1; end
            default:        begin m = 0;  u = 4; end
        endcase
        f = int'(j[3:0]) & ((1 << u) - 1);
        l = int'(j[3:0]) >> u;
        return m * (int'(j[7:4]) + 10 * int'(j[11:8]) + 100 * int'(j[15:12]) + 1000 * l) + f;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts falling edges until div_out is seen high
    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (div_out !== 1'b1 && n < 30000);
        if (div_out !== 1'b1) n = -1;
    endtask

    task automatic preset(input logic [15:0] j, input logic [2:0] code);
        mode_sel = code;
        jam      = j;
        step(3);
    endtask

    task automatic run_case(input logic [2:0] sel, input logic [15:0] j, input string req);
        int n, c;
        n = model_n(sel, j);
        preset(j, 3'b000);
        mode_sel = sel;
        wait_pulse(c);
        check(c == n + 1, {req, " R6 first pulse after arming"}, c, n + 1);
        step(1);
        check(div_out == 1'b0, {req, " R3 pulse width"}, int'(div_out), 0);
        wait_pulse(c);
        check(c + 1 == n, {req, " R3 R4 period"}, c + 1, n);
    endtask

    // Enter hold so that it is first seen at edge k after a pulse (N = 10)
    task automatic hold_near(input int k, input bit exp);
        int c;
        preset(16'h0010, 3'b000);
        mode_sel = 3'b110;
        wait_pulse(c);
        step(k - 1);
        mode_sel = 3'b000;
        step(10 - k + 1);
        check(div_out == exp, "R7 pulse at due time vs hold entry", int'(div_out), int'(exp));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [2:0]  modes [5] = '{3'b110, 3'b011, 3'b101, 3'b010, 3'b111};
        logic [15:0] jams  [5] = '{16'h0003, 16'h0026, 16'h00F0, 16'h0F06, 16'h1001};
        int c;
        bit quiet;

        // R9: reset state and arming after release
        step(5);
        check(div_out == 1'b0, "R9 output low in reset", int'(div_out), 0);
        rst = 1'b0;
        wait_pulse(c);
        check(c == model_n(3'b110, 16'h0005) + 1, "R9 first pulse after reset", c, 6);

        // R5 and R1: both hold codes keep the output low
        preset(16'h0003, 3'b000);
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (div_out !== 1'b0) quiet = 1'b0;
        end
        check(quiet, "R5 hold code 000 keeps output low", int'(!quiet), 0);
        preset(16'h0003, 3'b100);
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (div_out !== 1'b0) quiet = 1'b0;
        end
        check(quiet, "R1 R5 hold code 100 keeps output low", int'(!quiet), 0);

        // R2, R3, R4, R6: sweep of modes and jam words
        for (int mi = 0; mi < 5; mi++) begin
            for (int ji = 0; ji < 5; ji++) begin
                run_case(modes[mi], jams[ji], "R2");
            end
        end

        // R1: alias code for divide-by-5
        run_case(3'b001, 16'h0026, "R1 alias");

        // R10: maximum count in divide-by-8
        check(model_n(3'b011, 16'hFFFF) == 21327, "R10 model maximum", model_n(3'b011, 16'hFFFF), 21327);
        run_case(3'b011, 16'hFFFF, "R10");

        // R7: hold entered one, two and three edges before a pulse
        hold_near(10, 1'b1);
        step(1);
        check(div_out == 1'b0, "R7 single pulse after late hold", int'(div_out), 0);
        hold_near(9, 1'b1);
        step(1);
        check(div_out == 1'b0, "R7 single owed pulse", int'(div_out), 0);
        hold_near(8, 1'b0);

        // R8: latched output
        preset(16'h0010, 3'b000);
        latch_en = 1'b1;
        mode_sel = 3'b110;
        wait_pulse(c);
        step(4);
        check(div_out == 1'b1, "R8 output held by latch", int'(div_out), 1);
        latch_en = 1'b0;
        step(1);
        check(div_out == 1'b0, "R8 output released", int'(div_out), 0);
        wait_pulse(c);
        check(c == 5, "R8 R4 period unaffected by latch", c, 5);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule